// File: doc/BRIEF.md
# Dual-Clock FIFO with Write-Side Almost-Full Flag

This block is a 64-deep, 36-bit first-in first-out store that sits between two unrelated clock domains. A producer writes on `wr_clk` and a consumer reads on `rd_clk`. The producer watches one active-low status output, `afull_n`, which is generated entirely in the write-clock domain. The flag tells the producer that only a few free slots remain. How few is set by an offset X, which is captured from a two-bit preset select while reset is held.

Each pointer crosses into the other domain as a Gray code through two flip-flops. The write-side level is the write pointer minus the synchronised read pointer. This level drives a three-state machine with the following states:

- `AF_CLEAR`: the level is at least two below the threshold.
- `AF_NEAR`: the level is exactly one below the threshold.
- `AF_REACHED`: the level is at or above the threshold of 64−X.

The flag is low only in `AF_REACHED`. The machine is updated from the level as it will stand after the current edge. As a result, a write asserts the flag on the edge that stores it. Space freed by a read shows up only after the read pointer has passed both synchroniser stages, so the flag releases on the second write-clock rising edge after the read.

The machine has these transitions:

- `AF_CLEAR` to `AF_NEAR`: the projected level equals threshold−1.
- `AF_NEAR` to `AF_REACHED`: the projected level reaches the threshold.
- `AF_NEAR` to `AF_CLEAR`: the projected level falls to threshold−2 or lower.
- `AF_REACHED` to `AF_NEAR`: the projected level equals threshold−1.
- `AF_REACHED` to `AF_CLEAR`: the projected level falls to threshold−2 or lower.
- `AF_CLEAR` to `AF_REACHED`: a guard arc that cannot be reached in normal use, because writes raise the level by at most one per edge.

Top module: `dcfifo_afull`

## Requirements
- R1: Words leave on `rd_data` in the order they were accepted on the write port. The word read by an accepted read (`rd_en` high while not empty) appears on `rd_data` just after that same `rd_clk` rising edge and is held until the next accepted read.
- R2: The offset X is captured from `off_sel` on write-clock edges while `rst_n` is low: 0 gives 16, 1 gives 12, 2 gives 8 and 3 gives 4. Changing `off_sel` after reset has no effect on the threshold.
- R3: A write accepted on a `wr_clk` rising edge that brings the stored count to 64−X drives `afull_n` low right after that same edge.
- R4: When reads bring the count down to 63−X or fewer, `afull_n` stays low at the first `wr_clk` rising edge after the read's `rd_clk` edge. It goes high at the second such edge. The edges of the two clocks never coincide.
- R5: With no reads or writes in flight, `afull_n` is high exactly when the stored count is 63−X or fewer.
- R6: A write presented while 64 words are stored is discarded and never appears on the read side.
- R7: A read requested while the FIFO is empty is ignored, and `rd_data` keeps its last value.
- R8: While and directly after reset, `afull_n` is high, `rd_data` is zero and the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock; also clocks the flag logic |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low reset for both domains |
| off_sel | input | 2 | Offset preset select, captured during reset |
| wr_en | input | 1 | Write request |
| wr_data | input | 36 | Write data word |
| rd_en | input | 1 | Read request |
| rd_data | output | 36 | Registered read data |
| afull_n | output | 1 | Almost-full flag, low when the threshold is reached |

## Verification
The step check on the synchronised read pointer assumes that the read clock is no faster than the write clock. Under that assumption the write domain never sees the read pointer jump by more than one position per edge. The bench keeps to this with an 8 ns read clock against a 5 ns write clock.

The overflow and underflow properties assume the producer and consumer respect the internal full and empty guards. The bench only requests reads for words it knows are already visible to the read side. It only pushes past 64 words after the read pointer has had many write edges to settle. `off_sel` is held steady through each reset, and the clock phases are offset so that no input change or reset release lands on a sampling edge of either clock.

// File: rtl/dcfifo_pkg.sv
`timescale 1ns/1ps
package dcfifo_pkg;
    // fill conditions tracked by the write-side flag machine
    typedef enum logic [1:0] {
        AF_CLEAR   = 2'd0,
        AF_NEAR    = 2'd1,
        AF_REACHED = 2'd2
    } af_state_e;
endpackage

// File: rtl/dcfifo_ram.sv
`timescale 1ns/1ps
module dcfifo_ram #(
    parameter int DATA_W = 36,
    parameter int ADDR_W = 6
) (
    input  logic              wr_clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (wr_en) begin
            store[wr_addr] <= wr_data;
        end
    end

    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= store[rd_addr];
        end
    end
endmodule

// File: rtl/dcfifo_gray_sync.sv
`timescale 1ns/1ps
module dcfifo_gray_sync #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_s1,
    output logic [W-1:0] bin_s2
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    function automatic logic [W-1:0] gray_to_bin(input logic [W-1:0] g);
        logic [W-1:0] b;
        b[W-1] = g[W-1];
        for (int i = W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= gray_in;
            stage2 <= stage1;
        end
    end

    assign bin_s1 = gray_to_bin(stage1);
    assign bin_s2 = gray_to_bin(stage2);
endmodule

// File: rtl/dcfifo_afull_fsm.sv
`timescale 1ns/1ps
module dcfifo_afull_fsm
    import dcfifo_pkg::*;
#(
    parameter int PTR_W    = 7,
    parameter int DEPTH    = 64,
    parameter int OFF_MAX  = 16,
    parameter int OFF_STEP = 4,
    parameter int OFF_W    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       off_sel,
    input  logic [PTR_W-1:0] level_nxt,
    output logic             afull_n,
    output af_state_e        state_o,
    output logic [OFF_W-1:0] offset_o
);
    af_state_e        state_q;
    af_state_e        state_d;
    logic [OFF_W-1:0] offset_q;
    logic [OFF_W-1:0] preset;
    logic [PTR_W-1:0] thr;
    logic [PTR_W-1:0] thr_m1;
    logic             lvl_ge;
    logic             lvl_m1;

    // preset ladder: OFF_MAX, OFF_MAX-STEP, ...
    assign preset = OFF_W'(OFF_MAX) - OFF_W'(OFF_STEP * int'(off_sel));

    // offset captured while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            offset_q <= preset;
        end
    end

    assign thr    = PTR_W'(DEPTH) - PTR_W'(offset_q);
    assign thr_m1 = thr - PTR_W'(1);
    assign lvl_ge = (level_nxt >= thr);
    assign lvl_m1 = (level_nxt == thr_m1);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= AF_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            AF_CLEAR: begin
                if (lvl_ge)      state_d = AF_REACHED;
                else if (lvl_m1) state_d = AF_NEAR;
            end
            AF_NEAR: begin
                if (lvl_ge)       state_d = AF_REACHED;
                else if (!lvl_m1) state_d = AF_CLEAR;
            end
            AF_REACHED: begin
                if (!lvl_ge) state_d = lvl_m1 ? AF_NEAR : AF_CLEAR;
            end
            default: state_d = AF_CLEAR;
        endcase
    end

    // outputs
    always_comb begin
        afull_n  = (state_q != AF_REACHED);
        state_o  = state_q;
        offset_o = offset_q;
    end
endmodule

// File: rtl/dcfifo_afull.sv
`timescale 1ns/1ps
module dcfifo_afull
    import dcfifo_pkg::*;
#(
    parameter int DATA_W   = 36,
    parameter int ADDR_W   = 6,
    parameter int OFF_MAX  = 16,
    parameter int OFF_STEP = 4
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic [1:0]        off_sel,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              afull_n
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int PTR_W = ADDR_W + 1;
    localparam int OFF_W = $clog2(OFF_MAX + 1);

    // write domain
    logic [PTR_W-1:0] w_bin, w_bin_nxt, w_gray;
    logic [PTR_W-1:0] r_bin_ws1, r_bin_ws2;
    logic [PTR_W-1:0] w_level, level_nxt;
    logic             w_full, w_acc;
    af_state_e        fsm_state;
    logic [OFF_W-1:0] offset_q;

    // read domain
    logic [PTR_W-1:0] r_bin, r_bin_nxt, r_gray;
    logic [PTR_W-1:0] w_bin_rs1, w_bin_rs2;
    logic [PTR_W-1:0] r_level;
    logic             r_empty, r_acc;

    assign w_level   = w_bin - r_bin_ws2;
    assign w_full    = (w_level == PTR_W'(DEPTH));
    assign w_acc     = wr_en & ~w_full;
    assign w_bin_nxt = w_bin + PTR_W'(w_acc);
    // level as it stands after this edge, using the newest synchronised read pointer
    assign level_nxt = w_bin_nxt - r_bin_ws1;

    always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n) begin
            w_bin  <= '0;
            w_gray <= '0;
        end else begin
            w_bin  <= w_bin_nxt;
            w_gray <= w_bin_nxt ^ (w_bin_nxt >> 1);
        end
    end

    assign r_level   = w_bin_rs2 - r_bin;
    assign r_empty   = (r_level == '0);
    assign r_acc     = rd_en & ~r_empty;
    assign r_bin_nxt = r_bin + PTR_W'(r_acc);

    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) begin
            r_bin  <= '0;
            r_gray <= '0;
        end else begin
            r_bin  <= r_bin_nxt;
            r_gray <= r_bin_nxt ^ (r_bin_nxt >> 1);
        end
    end

    dcfifo_gray_sync #(.W(PTR_W)) u_rptr_sync (
        .clk     (wr_clk),
        .rst_n   (rst_n),
        .gray_in (r_gray),
        .bin_s1  (r_bin_ws1),
        .bin_s2  (r_bin_ws2)
    );

    dcfifo_gray_sync #(.W(PTR_W)) u_wptr_sync (
        .clk     (rd_clk),
        .rst_n   (rst_n),
        .gray_in (w_gray),
        .bin_s1  (w_bin_rs1),
        .bin_s2  (w_bin_rs2)
    );

    dcfifo_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
        .wr_clk  (wr_clk),
        .wr_en   (w_acc),
        .wr_addr (w_bin[ADDR_W-1:0]),
        .wr_data (wr_data),
        .rd_clk  (rd_clk),
        .rst_n   (rst_n),
        .rd_en   (r_acc),
        .rd_addr (r_bin[ADDR_W-1:0]),
        .rd_data (rd_data)
    );

    dcfifo_afull_fsm #(
        .PTR_W    (PTR_W),
        .DEPTH    (DEPTH),
        .OFF_MAX  (OFF_MAX),
        .OFF_STEP (OFF_STEP),
        .OFF_W    (OFF_W)
    ) u_fsm (
        .clk       (wr_clk),
        .rst_n     (rst_n),
        .off_sel   (off_sel),
        .level_nxt (level_nxt),
        .afull_n   (afull_n),
        .state_o   (fsm_state),
        .offset_o  (offset_q)
    );
endmodule

// File: rtl/dcfifo_afull_chk.sv
`timescale 1ns/1ps
module dcfifo_afull_chk
    import dcfifo_pkg::*;
#(
    parameter int PTR_W = 7,
    parameter int DEPTH = 64,
    parameter int OFF_W = 5
) (
    input logic             wr_clk,
    input logic             rd_clk,
    input logic             rst_n,
    input logic             afull_n,
    input logic             w_acc,
    input logic [PTR_W-1:0] w_level,
    input logic [PTR_W-1:0] r_level,
    input logic [PTR_W-1:0] r_bin,
    input logic [PTR_W-1:0] w_bin_rs1,
    input logic [PTR_W-1:0] r_bin_ws1,
    input logic [OFF_W-1:0] offset_q,
    input af_state_e        fsm_state
);
    // R6: write side never holds more than the depth
    a_r6_no_overflow: assert property (@(posedge wr_clk) disable iff (!rst_n)
        w_level <= PTR_W'(DEPTH));

    // R7: read side never drains past empty
    a_r7_no_underflow: assert property (@(posedge rd_clk) disable iff (!rst_n)
        r_level <= PTR_W'(DEPTH));

    a_r7_stage1_order: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (w_bin_rs1 - r_bin) <= PTR_W'(DEPTH));

    // R3: the flag only drops on an edge that stored a word
    a_r3_fall_on_write: assert property (@(posedge wr_clk) disable iff (!rst_n)
        $fell(afull_n) |-> $past(w_acc));

    // R3: no jump from clear straight to reached
    a_r3_no_skip: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (fsm_state == AF_CLEAR) |=> (fsm_state != AF_REACHED));

    // R4: release only after the first sync stage took a new read pointer one edge earlier
    a_r4_release_after_sync: assert property (@(posedge wr_clk) disable iff (!rst_n)
        $rose(afull_n) |-> ($past(r_bin_ws1) != $past(r_bin_ws1, 2)));

    // R4: synchronised read pointer advances at most one step per write edge
    a_r4_sync_step: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (r_bin_ws1 - $past(r_bin_ws1)) <= PTR_W'(1));

    // R2: offset frozen outside reset
    a_r2_offset_held: assert property (@(posedge wr_clk) disable iff (!rst_n)
        $stable(offset_q));
endmodule

bind dcfifo_afull dcfifo_afull_chk #(
    .PTR_W (PTR_W),
    .DEPTH (DEPTH),
    .OFF_W (OFF_W)
) u_chk (
    .wr_clk    (wr_clk),
    .rd_clk    (rd_clk),
    .rst_n     (rst_n),
    .afull_n   (afull_n),
    .w_acc     (w_acc),
    .w_level   (w_level),
    .r_level   (r_level),
    .r_bin     (r_bin),
    .w_bin_rs1 (w_bin_rs1),
    .r_bin_ws1 (r_bin_ws1),
    .offset_q  (offset_q),
    .fsm_state (fsm_state)
);

// File: tb/dcfifo_afull_bench.sv
`timescale 1ns/1ps
module dcfifo_afull_bench;
    logic        wr_clk = 1'b0;
    logic        rd_clk = 1'b0;
    logic        rst_n  = 1'b0;
    logic [1:0]  off_sel = 2'd0;
    logic        wr_en  = 1'b0;
    logic [35:0] wr_data = '0;
    logic        rd_en  = 1'b0;
    logic [35:0] rd_data;
    logic        afull_n;

    dcfifo_afull u_dcfifo_afull (
        .wr_clk  (wr_clk),
        .rd_clk  (rd_clk),
        .rst_n   (rst_n),
        .off_sel (off_sel),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_data (rd_data),
        .afull_n (afull_n)
    );

    // 200 MHz write clock; 125 MHz read clock with rising edges on whole ns
    always #2.5 wr_clk = ~wr_clk;
    initial begin
        #1;
        forever begin
            rd_clk = 1'b1;
            #4;
            rd_clk = 1'b0;
            #4;
        end
    end

    int          n_vec = 0;
    int          n_bad = 0;
    int          wr_total, rd_total, rd_seen_prev, thr_m, seq;
    logic        exp_af_n = 1'b1;
    logic        prev_exp = 1'b1;
    logic [35:0] sb_q[$];
    logic [35:0] exp_rd = '0;
    logic        rd_chk = 1'b0;
    logic        rd_was_empty = 1'b0;
    logic        ovf_phase = 1'b0;
    logic        done = 1'b0;
    int          cyc = 0;

    function automatic logic [35:0] mk_word(input int s);
        return {4'(s), 32'(s * 32'h9E37_79B1)};
    endfunction

    // write-side reference: count model, read seen one write edge late
    always @(posedge wr_clk) begin
        if (rst_n) begin
            if (wr_en && (wr_total - rd_total) < 64) begin
                sb_q.push_back(wr_data);
                wr_total++;
            end
            prev_exp     = exp_af_n;
            exp_af_n     = !((wr_total - rd_seen_prev) >= thr_m);
            rd_seen_prev = rd_total;
        end
    end

    always @(negedge wr_clk) begin
        if (rst_n) begin
            n_vec++;
            if (afull_n !== exp_af_n) begin
                n_bad++;
                if (!exp_af_n && prev_exp)
                    $display("FAIL R3 afull_n=%b expected %b t=%0t", afull_n, exp_af_n, $time);
                else if (exp_af_n && prev_exp)
                    $display("FAIL R5 afull_n=%b expected %b t=%0t", afull_n, exp_af_n, $time);
                else
                    $display("FAIL R4 afull_n=%b expected %b t=%0t", afull_n, exp_af_n, $time);
            end
        end
    end

    // read monitor
    always @(posedge rd_clk) begin
        if (rst_n && rd_en) begin
            rd_chk = 1'b1;
            rd_was_empty = (sb_q.size() == 0);
            if (!rd_was_empty) begin
                exp_rd = sb_q.pop_front();
                rd_total++;
            end
        end
    end

    always @(negedge rd_clk) begin
        if (rd_chk) begin
            rd_chk = 1'b0;
            n_vec++;
            if (rd_data !== exp_rd) begin
                n_bad++;
                if (rd_was_empty && ovf_phase)
                    $display("FAIL R6 rd_data=%h expected %h", rd_data, exp_rd);
                else if (rd_was_empty)
                    $display("FAIL R7 rd_data=%h expected %h", rd_data, exp_rd);
                else
                    $display("FAIL R1 rd_data=%h expected %h", rd_data, exp_rd);
            end
        end
    end

    task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic write_n(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge wr_clk);
            wr_en = 1'b1;
            wr_data = mk_word(seq);
            seq++;
        end
        @(negedge wr_clk);
        wr_en = 1'b0;
    endtask

    task automatic read_n(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            @(negedge rd_clk);
            rd_en = 1'b1;
            @(negedge rd_clk);
            rd_en = 1'b0;
            repeat (gap) @(negedge rd_clk);
        end
    endtask

    task automatic drain();
        @(negedge rd_clk);
        while (sb_q.size() > 0) begin
            rd_en = 1'b1;
            @(negedge rd_clk);
        end
        rd_en = 1'b0;
    endtask

    task automatic do_reset(input logic [1:0] sel);
        @(negedge wr_clk);
        rst_n = 1'b0;
        off_sel = sel;
        wr_en = 1'b0;
        rd_en = 1'b0;
        repeat (4) @(negedge wr_clk);
        sb_q.delete();
        wr_total = 0;
        rd_total = 0;
        rd_seen_prev = 0;
        exp_af_n = 1'b1;
        prev_exp = 1'b1;
        exp_rd = '0;
        rd_chk = 1'b0;
        thr_m = 64 - (16 - 4 * int'(sel));
        #1.3;
        rst_n = 1'b1;
        check("R8 afull_n after reset", 36'(afull_n), 36'd1);
        check("R8 rd_data after reset", rd_data, 36'd0);
    endtask

    initial begin
        seq = 1;
        for (int s = 0; s < 4; s++) begin
            do_reset(2'(s));
            // R2: later changes of the select are ignored
            off_sel = 2'(s) ^ 2'd3;
            write_n(thr_m - 1);
            repeat (6) @(negedge wr_clk);
            check("R2 flag high one below threshold", 36'(afull_n), 36'd1);
            write_n(1);
            check("R3 flag low on threshold write", 36'(afull_n), 36'd0);
            write_n(2);
            repeat (5) @(negedge wr_clk);
            // R4: spaced reads, release timing checked every write edge
            read_n(3, 5);
            repeat (6) @(negedge wr_clk);
            check("R5 flag high after release", 36'(afull_n), 36'd1);
            read_n(7, 1);
            repeat (8) @(negedge wr_clk);
            // mixed traffic around the threshold
            fork
                begin
                    for (int i = 0; i < 64; i++) begin
                        @(negedge wr_clk);
                        wr_en = (i % 8 < 5);
                        wr_data = mk_word(seq);
                        if (i % 8 < 5) seq++;
                    end
                    @(negedge wr_clk);
                    wr_en = 1'b0;
                end
                begin
                    for (int i = 0; i < 50; i++) begin
                        @(negedge rd_clk);
                        rd_en = (i % 5 != 2);
                    end
                    @(negedge rd_clk);
                    rd_en = 1'b0;
                end
            join
            repeat (8) @(negedge wr_clk);
            drain();
            repeat (6) @(negedge rd_clk);
            // R7: read on empty
            read_n(1, 2);
            // R6: push one past capacity
            repeat (6) @(negedge wr_clk);
            write_n(65);
            repeat (8) @(negedge wr_clk);
            check("R6 flag low when full", 36'(afull_n), 36'd0);
            drain();
            repeat (6) @(negedge rd_clk);
            ovf_phase = 1'b1;
            read_n(1, 2);
            ovf_phase = 1'b0;
            repeat (6) @(negedge wr_clk);
            check("R5 flag high when empty", 36'(afull_n), 36'd1);
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    always @(posedge wr_clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule